// File: doc/BRIEF.md
# Event Timer with One Compare Channel

This block is a memory-mapped timer peripheral. It holds a free-running 64-bit up counter and a single compare channel. Software programs them through a plain 32-bit register port: a write strobe, a byte address and write data, with read data returned combinationally for the address presented. Every 64-bit quantity is reached as two 32-bit words, the low word at the lower address.

The compare channel runs in one of two modes. In one-shot mode it signals once, when the counter reaches or passes the programmed match value. In periodic mode it signals each time the counter equals the match value, and the hardware then advances the match value by a stored step. The step and the match value are loaded together only when software arms a one-time value-set flag before the comparator write. The interrupt output can be a one-cycle pulse or a held level that software acknowledges by writing 1 to a status bit. A route output carries either the channel's own 5-bit route field or a fixed legacy line number.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter reads 0, general configuration reads 0, status reads 0, the channel configuration word reads 0x30, both comparator words read 0xFFFFFFFF, and irq_o and irq_route_o are 0.
- R2: The capability low word (offset 0x000) reads 0x2000: bit 13 set for a 64-bit counter, bits 12:8 holding channel count minus one (0). The high word (0x004) reads the tick period in femtoseconds (parameter PERIOD_FS). Writes to either word change nothing.
- R3: While general configuration (0x010) bit 0 is set, the counter (0x0F0 low, 0x0F4 high) advances by one every clock, carrying from the low word into the high word. While bit 0 is clear it holds its value.
- R4: Counter word writes take effect only while counting is disabled. While counting is enabled they are ignored.
- R5: In one-shot mode (channel configuration at 0x100, bit 3 = 0), once counting runs and the counter is equal to or above the comparator (0x108 low, 0x10C high), the channel fires exactly once. A match value already behind the counter fires at once. Firing is re-armed only by a comparator write. The interrupt appears one cycle after the counter first meets the condition, so the counter then reads match value + 1, or start value + 1 if it started beyond the match value.
- R6: In periodic mode (bit 3 = 1) with value-set (bit 6) armed, a comparator write loads both the match value and the step. A write of the high word clears value-set. Each match, where the counter equals the comparator, fires and adds the step to the comparator.
- R7: In periodic mode with value-set clear, a comparator write changes only the step. The match value in use is left unchanged.
- R8: In edge mode (bit 1 = 0) each match gives a one-cycle high pulse on irq_o, and status (0x020 bit 0) stays 0.
- R9: In level mode (bit 1 = 1) a match sets status bit 0. irq_o stays high until software writes 1 to that bit. Writing 0 has no effect.
- R10: With interrupt enable (bit 2) clear, irq_o stays low; the level-mode status bit is still set by a match.
- R11: While 32-bit mode (bit 8) is set, a comparator low-word write clears the comparator's upper 32 bits, and a high-word write is ignored.
- R12: irq_route_o presents channel configuration bits 13:9 when general configuration bit 1 is clear, and the parameter LEGACY_ROUTE when it is set.
- R13: Unimplemented bits and words read as zero: the upper words at 0x014, 0x024 and 0x104, and unmapped offsets. Bits 4 and 5 of the channel configuration read 1 whatever is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one word per cycle |
| bus_addr_i | input | 12 | Byte address of the word accessed |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Interrupt, pulse or level per channel setting |
| irq_route_o | output | 5 | Interrupt line number for irq_o |

## Verification
One-shot behaviour is swept over every pairing of a small set of counter start values and match values. Match values behind, at and just ahead of the counter are included, which separates a greater-or-equal test from a pure equality and shows whether a late write is missed. The periodic sweep covers every pairing of a small range of initial match values with a small range of later steps. Per-cycle interrupt samples are checked against the counter value, which exposes a wrong reload, a step taken from the wrong write and an off-by-one in the match pipeline. Directed sequences cover level hold and acknowledge, the enable gate, 32-bit mode writes, route selection and counter carry.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 12;
    localparam int ROUTE_W = 5;
    localparam int NUM_CH  = 1;

    localparam logic [ADDR_W-1:0] OFS_CAP_LO  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CAP_HI  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_GCFG    = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_STAT    = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 12'h0F0;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 12'h0F4;
    localparam logic [ADDR_W-1:0] OFS_CCFG    = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_CMP_LO  = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_CMP_HI  = 12'h10C;

    // channel configuration bit positions
    localparam int CB_LEVEL   = 1;
    localparam int CB_IE      = 2;
    localparam int CB_PER     = 3;
    localparam int CB_PERCAP  = 4;
    localparam int CB_WIDECAP = 5;
    localparam int CB_VSET    = 6;
    localparam int CB_M32     = 8;
    localparam int CB_ROUTE   = 9;

    // capability low word positions
    localparam int CAP_NCH_LSB = 8;
    localparam int CAP_WIDE    = 13;

    typedef struct packed {
        logic               level;
        logic               ie;
        logic               periodic;
        logic               vset;
        logic               m32;
        logic [ROUTE_W-1:0] route;
    } chan_cfg_t;

    typedef struct packed {
        logic run;
        logic legacy;
    } gen_cfg_t;

endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic [HALF_W-1:0]   wdata_i,
    output logic [2*HALF_W-1:0] cnt_o
);
    localparam int W = 2 * HALF_W;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run_i) begin
            cnt_d = cnt_q + W'(1);
        end else begin
            if (wr_lo_i) cnt_d[HALF_W-1:0] = wdata_i;
            if (wr_hi_i) cnt_d[W-1:HALF_W] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) run_i |=> cnt_q == $past(cnt_q) + W'(1)); // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_timer_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic [2*HALF_W-1:0] cnt_i,
    input  logic                cfg_wr_i,
    input  logic                cmp_wr_lo_i,
    input  logic                cmp_wr_hi_i,
    input  logic [HALF_W-1:0]   wdata_i,
    output chan_cfg_t           cfg_o,
    output logic [2*HALF_W-1:0] cmp_o,
    output logic                match_o
);
    localparam int W = 2 * HALF_W;

    typedef struct packed {
        chan_cfg_t    cfg;
        logic [W-1:0] cmp;
        logic [W-1:0] step;
        logic         armed;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        hit;
    logic        load_cmp;

    always_comb begin
        if (st_q.cfg.periodic) hit = run_i && (cnt_i == st_q.cmp);
        else                   hit = run_i && st_q.armed && (cnt_i >= st_q.cmp);

        // comparator value is loaded in one-shot mode, or in periodic mode when value-set is armed
        load_cmp = !st_q.cfg.periodic || st_q.cfg.vset;

        st_d = st_q;

        if (hit) begin
            if (st_q.cfg.periodic) st_d.cmp   = st_q.cmp + st_q.step;
            else                   st_d.armed = 1'b0;
        end

        if (cfg_wr_i) begin
            st_d.cfg.level    = wdata_i[CB_LEVEL];
            st_d.cfg.ie       = wdata_i[CB_IE];
            st_d.cfg.periodic = wdata_i[CB_PER];
            st_d.cfg.vset     = wdata_i[CB_VSET];
            st_d.cfg.m32      = wdata_i[CB_M32];
            st_d.cfg.route    = wdata_i[CB_ROUTE +: ROUTE_W];
        end

        if (cmp_wr_lo_i) begin
            st_d.armed = 1'b1;
            if (load_cmp) begin
                st_d.cmp[HALF_W-1:0] = wdata_i;
                if (st_q.cfg.m32) st_d.cmp[W-1:HALF_W] = '0;
            end
            if (st_q.cfg.periodic) begin
                st_d.step[HALF_W-1:0] = wdata_i;
                if (st_q.cfg.m32) begin
                    st_d.step[W-1:HALF_W] = '0;
                    st_d.cfg.vset         = 1'b0;
                end
            end
        end

        if (cmp_wr_hi_i && !st_q.cfg.m32) begin
            st_d.armed = 1'b1;
            if (load_cmp) st_d.cmp[W-1:HALF_W] = wdata_i;
            if (st_q.cfg.periodic) begin
                st_d.step[W-1:HALF_W] = wdata_i;
                st_d.cfg.vset         = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg   <= '0;
            st_q.cmp   <= '1;
            st_q.step  <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o   = st_q.cfg;
    assign cmp_o   = st_q.cmp;
    assign match_o = hit;

    AST_ONESHOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n) (!st_q.cfg.periodic && match_o && !cmp_wr_lo_i && !cmp_wr_hi_i && !cfg_wr_i) |=> !match_o); // R5
    AST_VSET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (st_q.cfg.periodic && st_q.cfg.vset && cmp_wr_hi_i && !st_q.cfg.m32) |=> !cfg_o.vset); // R6
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) (st_q.cfg.periodic && match_o && st_q.step != '0 && !cmp_wr_lo_i && !cmp_wr_hi_i && !cfg_wr_i) |=> cmp_o != $past(cmp_o)); // R6
    AST_NOVSET_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (st_q.cfg.periodic && !st_q.cfg.vset && cmp_wr_lo_i && !match_o) |=> $stable(cmp_o)); // R7
    AST_M32_UPPER: assert property (@(posedge clk) disable iff (!rst_n) (st_q.cfg.m32 && cmp_wr_lo_i && load_cmp) |=> cmp_o[W-1:HALF_W] == '0); // R11

endmodule

// File: rtl/evt_irq.sv
module evt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic match_i,
    input  logic level_i,
    input  logic ie_i,
    input  logic clr_i,
    output logic status_o,
    output logic irq_o
);
    typedef struct packed {
        logic status;
        logic pulse;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = match_i;
        if (clr_i && level_i)   st_d.status = 1'b0;
        if (match_i && level_i) st_d.status = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign irq_o    = run_i && ie_i && (level_i ? st_q.status : st_q.pulse);

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (status_o && !(clr_i && level_i)) |=> status_o); // R9
    AST_EDGE_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n) (!level_i && !status_o) |=> !status_o); // R8

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter logic [BUS_W-1:0]   PERIOD_FS    = 32'd8000000,
    parameter logic [ROUTE_W-1:0] LEGACY_ROUTE = 5'd2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [BUS_W-1:0]   bus_wdata_i,
    output logic [BUS_W-1:0]   bus_rdata_o,
    output logic               irq_o,
    output logic [ROUTE_W-1:0] irq_route_o
);
    localparam int CNT_W = 2 * BUS_W;
    localparam logic [4:0] NCH_M1 = 5'(NUM_CH - 1);

    gen_cfg_t         gcfg_d, gcfg_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp;
    chan_cfg_t        ccfg;
    logic             match;
    logic             status;

    logic wr_gcfg, wr_stat, wr_cnt_lo, wr_cnt_hi, wr_ccfg, wr_cmp_lo, wr_cmp_hi;

    always_comb begin
        wr_gcfg   = bus_wr_i && (bus_addr_i == OFS_GCFG);
        wr_stat   = bus_wr_i && (bus_addr_i == OFS_STAT);
        wr_cnt_lo = bus_wr_i && (bus_addr_i == OFS_CNT_LO);
        wr_cnt_hi = bus_wr_i && (bus_addr_i == OFS_CNT_HI);
        wr_ccfg   = bus_wr_i && (bus_addr_i == OFS_CCFG);
        wr_cmp_lo = bus_wr_i && (bus_addr_i == OFS_CMP_LO);
        wr_cmp_hi = bus_wr_i && (bus_addr_i == OFS_CMP_HI);
    end

    always_comb begin
        gcfg_d = gcfg_q;
        if (wr_gcfg) begin
            gcfg_d.run    = bus_wdata_i[0];
            gcfg_d.legacy = bus_wdata_i[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gcfg_q <= '0;
        else        gcfg_q <= gcfg_d;
    end

    evt_counter #(.HALF_W(BUS_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (gcfg_q.run),
        .wr_lo_i (wr_cnt_lo),
        .wr_hi_i (wr_cnt_hi),
        .wdata_i (bus_wdata_i),
        .cnt_o   (cnt)
    );

    evt_channel #(.HALF_W(BUS_W)) u_chan (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (gcfg_q.run),
        .cnt_i       (cnt),
        .cfg_wr_i    (wr_ccfg),
        .cmp_wr_lo_i (wr_cmp_lo),
        .cmp_wr_hi_i (wr_cmp_hi),
        .wdata_i     (bus_wdata_i),
        .cfg_o       (ccfg),
        .cmp_o       (cmp),
        .match_o     (match)
    );

    evt_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (gcfg_q.run),
        .match_i  (match),
        .level_i  (ccfg.level),
        .ie_i     (ccfg.ie),
        .clr_i    (wr_stat && bus_wdata_i[0]),
        .status_o (status),
        .irq_o    (irq_o)
    );

    logic [BUS_W-1:0] cap_lo_word;
    logic [BUS_W-1:0] ccfg_word;

    always_comb begin
        cap_lo_word                       = '0;
        cap_lo_word[CAP_NCH_LSB +: 5]     = NCH_M1;
        cap_lo_word[CAP_WIDE]             = 1'b1;

        ccfg_word                         = '0;
        ccfg_word[CB_LEVEL]               = ccfg.level;
        ccfg_word[CB_IE]                  = ccfg.ie;
        ccfg_word[CB_PER]                 = ccfg.periodic;
        ccfg_word[CB_PERCAP]              = 1'b1;
        ccfg_word[CB_WIDECAP]             = 1'b1;
        ccfg_word[CB_VSET]                = ccfg.vset;
        ccfg_word[CB_M32]                 = ccfg.m32;
        ccfg_word[CB_ROUTE +: ROUTE_W]    = ccfg.route;
    end

    always_comb begin
        case (bus_addr_i)
            OFS_CAP_LO: bus_rdata_o = cap_lo_word;
            OFS_CAP_HI: bus_rdata_o = PERIOD_FS;
            OFS_GCFG:   bus_rdata_o = {{(BUS_W-2){1'b0}}, gcfg_q.legacy, gcfg_q.run};
            OFS_STAT:   bus_rdata_o = {{(BUS_W-1){1'b0}}, status};
            OFS_CNT_LO: bus_rdata_o = cnt[BUS_W-1:0];
            OFS_CNT_HI: bus_rdata_o = cnt[CNT_W-1:BUS_W];
            OFS_CCFG:   bus_rdata_o = ccfg_word;
            OFS_CMP_LO: bus_rdata_o = cmp[BUS_W-1:0];
            OFS_CMP_HI: bus_rdata_o = cmp[CNT_W-1:BUS_W];
            default:    bus_rdata_o = '0;
        endcase
    end

    assign irq_route_o = gcfg_q.legacy ? LEGACY_ROUTE : ccfg.route;

endmodule

// File: tb/sim_evt_timer.sv
module sim_evt_timer;

    localparam logic [11:0] A_CAP_LO = 12'h000, A_CAP_HI = 12'h004;
    localparam logic [11:0] A_GCFG = 12'h010, A_GCFG_HI = 12'h014;
    localparam logic [11:0] A_STAT = 12'h020, A_STAT_HI = 12'h024;
    localparam logic [11:0] A_CNT_LO = 12'h0F0, A_CNT_HI = 12'h0F4;
    localparam logic [11:0] A_CCFG = 12'h100, A_CCFG_HI = 12'h104;
    localparam logic [11:0] A_CMP_LO = 12'h108, A_CMP_HI = 12'h10C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [11:0] bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        irq_o;
    logic [4:0]  irq_route_o;

    int nvec = 0;
    int nerr = 0;

    evt_timer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o),
        .irq_route_o (irq_route_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr_i  = a;
        bus_wdata_i = d;
        bus_wr_i    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr_i    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr_i = a;
        #1;
        d = bus_rdata_o;
    endtask

    task automatic prep(input logic [31:0] c);
        wr(A_GCFG, 32'h0);
        wr(A_CNT_LO, c);
        wr(A_CNT_HI, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CNT_LO, v); chk("R1 cnt lo", v, 0);
        rd(A_CNT_HI, v); chk("R1 cnt hi", v, 0);
        rd(A_GCFG, v);   chk("R1 gcfg", v, 0);
        rd(A_STAT, v);   chk("R1 stat", v, 0);
        rd(A_CCFG, v);   chk("R1 ccfg", v, 32'h30);
        rd(A_CMP_LO, v); chk("R1 cmp lo", v, 32'hFFFFFFFF);
        rd(A_CMP_HI, v); chk("R1 cmp hi", v, 32'hFFFFFFFF);
        chk("R1 irq", irq_o, 0);
        chk("R1 route", irq_route_o, 0);

        // R2 capability words, read-only
        rd(A_CAP_LO, v); chk("R2 cap lo", v, 32'h2000);
        rd(A_CAP_HI, v); chk("R2 cap hi", v, 32'd8000000);
        wr(A_CAP_LO, 32'hFFFFFFFF);
        wr(A_CAP_HI, 32'h0);
        rd(A_CAP_LO, v); chk("R2 cap lo after write", v, 32'h2000);
        rd(A_CAP_HI, v); chk("R2 cap hi after write", v, 32'd8000000);

        // R13 unimplemented bits and read-only capability bits
        wr(A_CCFG, 32'hFFFFFFFF);
        rd(A_CCFG, v);    chk("R13 ccfg all ones", v, 32'h3F7E);
        rd(A_CCFG_HI, v); chk("R13 ccfg hi", v, 0);
        wr(A_CCFG, 32'h0);
        rd(A_CCFG, v);    chk("R13 ccfg cap bits stay", v, 32'h30);
        rd(A_GCFG_HI, v); chk("R13 gcfg hi", v, 0);
        rd(A_STAT_HI, v); chk("R13 stat hi", v, 0);
        rd(12'h200, v);   chk("R13 unmapped", v, 0);

        // R3 counting and hold, with carry
        prep(32'h0);
        wr(A_GCFG, 32'h1);
        rd(A_CNT_LO, v); chk("R3 cnt at enable", v, 0);
        repeat (10) @(negedge clk);
        rd(A_CNT_LO, v); chk("R3 cnt after 10", v, 10);
        wr(A_GCFG, 32'h0);
        rd(A_CNT_LO, v); chk("R3 cnt at disable", v, 11);
        repeat (5) @(negedge clk);
        rd(A_CNT_LO, v); chk("R3 cnt held", v, 11);
        wr(A_CNT_LO, 32'hFFFFFFFE);
        wr(A_CNT_HI, 32'h1);
        wr(A_GCFG, 32'h1);
        repeat (3) @(negedge clk);
        rd(A_CNT_LO, v); chk("R3 carry lo", v, 1);
        rd(A_CNT_HI, v); chk("R3 carry hi", v, 2);

        // R4 counter write ignored while running
        rd(A_CNT_LO, v);
        wr(A_CNT_LO, 32'h55);
        rd(A_CNT_LO, v2); chk("R4 write while running", v2, v + 1);

        // R5 / R8 one-shot sweep, edge mode
        for (int c0 = 0; c0 < 6; c0++) begin
            for (int t = 0; t < 8; t++) begin
                int mx;
                mx = (t > c0) ? t : c0;
                prep(c0);
                wr(A_CCFG, 32'h04);
                wr(A_CMP_LO, t);
                wr(A_CMP_HI, 32'h0);
                wr(A_GCFG, 32'h1);
                pulses = 0;
                for (int i = 0; i < 16; i++) begin
                    rd(A_CNT_LO, v);
                    if (irq_o) pulses++;
                    chk("R5 oneshot irq", irq_o, (v == mx + 1) ? 1 : 0);
                    @(negedge clk);
                end
                chk("R5 oneshot single fire", pulses, 1);
            end
        end
        rd(A_STAT, v); chk("R8 edge status stays 0", v, 0);

        // R6 / R7 periodic sweep, edge mode
        for (int s = 1; s < 7; s++) begin
            for (int p = 1; p < 7; p++) begin
                prep(32'h0);
                wr(A_CCFG, 32'h4C);
                wr(A_CMP_LO, s);
                wr(A_CMP_HI, 32'h0);
                rd(A_CCFG, v); chk("R6 value-set cleared", v, 32'h3C);
                if (p != s) begin
                    wr(A_CMP_LO, p);
                    rd(A_CMP_LO, v); chk("R7 match value kept", v, s);
                end
                wr(A_GCFG, 32'h1);
                for (int i = 0; i < 30; i++) begin
                    logic e;
                    rd(A_CNT_LO, v);
                    e = (v >= s + 1) && (((v - 1 - s) % p) == 0);
                    chk((p == s) ? "R6 periodic irq" : "R7 periodic step irq", irq_o, e);
                    @(negedge clk);
                end
            end
        end

        // R9 level mode hold and acknowledge
        prep(32'h0);
        wr(A_CCFG, 32'h06);
        wr(A_CMP_LO, 32'h3);
        wr(A_CMP_HI, 32'h0);
        wr(A_GCFG, 32'h1);
        repeat (8) @(negedge clk);
        chk("R9 level irq held", irq_o, 1);
        rd(A_STAT, v); chk("R9 status set", v, 1);
        wr(A_STAT, 32'h0);
        chk("R9 write 0 keeps irq", irq_o, 1);
        wr(A_STAT, 32'h1);
        chk("R9 write 1 drops irq", irq_o, 0);
        rd(A_STAT, v); chk("R9 status cleared", v, 0);

        // R10 enable gate
        prep(32'h0);
        wr(A_CCFG, 32'h02);
        wr(A_CMP_LO, 32'h2);
        wr(A_CMP_HI, 32'h0);
        wr(A_GCFG, 32'h1);
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            if (irq_o) pulses++;
            @(negedge clk);
        end
        chk("R10 no irq without enable", pulses, 0);
        rd(A_STAT, v); chk("R10 status still set", v, 1);
        wr(A_STAT, 32'h1);

        // R11 32-bit mode comparator writes
        wr(A_GCFG, 32'h0);
        wr(A_CCFG, 32'h0);
        wr(A_CMP_HI, 32'hAAAA5555);
        wr(A_CMP_LO, 32'h11);
        rd(A_CMP_HI, v); chk("R11 full write hi", v, 32'hAAAA5555);
        wr(A_CCFG, 32'h100);
        wr(A_CMP_LO, 32'h22);
        rd(A_CMP_LO, v); chk("R11 m32 lo", v, 32'h22);
        rd(A_CMP_HI, v); chk("R11 m32 clears hi", v, 0);
        wr(A_CMP_HI, 32'h77);
        rd(A_CMP_HI, v); chk("R11 m32 hi write ignored", v, 0);

        // R12 route selection
        wr(A_CCFG, 32'd19 << 9);
        chk("R12 channel route", irq_route_o, 19);
        wr(A_GCFG, 32'h2);
        chk("R12 legacy route", irq_route_o, 2);
        wr(A_GCFG, 32'h0);
        chk("R12 channel route again", irq_route_o, 19);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule